// File: doc/BRIEF.md
# Set/Clear Register GPIO Port

This block is a memory-mapped general-purpose I/O port. Each pin has one bit in every register, at the position equal to the pin number. Software changes pin direction and output level by writing masks to separate set and clear addresses. Bits written as 1 take effect and bits written as 0 leave the latch alone, so no read-modify-write sequence is ever needed. Several addresses mean one thing when read and another when written. A read returns the current state, and a write changes it.

The bus is a plain 32-bit register interface with an address, a write strobe, write data, a read strobe and registered read data. It has no back-pressure: every strobe is accepted in the cycle it is presented, and read data follows one cycle later. Pin levels are not sampled until software writes any value to the pin-state address. From then on each level passes through a two-flop synchronizer before it can be read.

Top module: `gpio_sc_port`

## Requirements
- R1: After reset, `pin_oe`, `pin_out` and `bus_rdata` are all zero and pin sampling is off.
- R2: A write to offset 0x104 sets every `pin_oe` bit whose write-data bit is 1 (bit i is pin i). Bits written as 0 keep their value. Reads of 0x104 return 0.
- R3: A write to offset 0x100 clears every `pin_oe` bit whose write-data bit is 1 and keeps the others. A read of 0x100 returns `pin_oe`.
- R4: A write to offset 0x108 sets every `pin_out` bit whose write-data bit is 1 and keeps the others. A read of 0x108 returns the output latch.
- R5: A write to offset 0x10C clears every `pin_out` bit whose write-data bit is 1 and keeps the others. Reads of 0x10C return 0.
- R6: While sampling is off, a read of offset 0x110 returns 0 whatever `pin_in` holds.
- R7: A write of any data, including 0, to offset 0x110 turns sampling on. It stays on until reset.
- R8: With sampling on, a read of 0x110 returns `pin_in` delayed by two clock edges. A read captured at edge k returns the level `pin_in` had just before edge k-2.
- R9: `bus_rdata` is loaded at the clock edge where `bus_rd` is high. It shows the state from before any write in that same cycle, and it holds its value until the next read.
- R10: Reads of any other offset return 0, and writes to any other offset change no output and no readable state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data / bit mask |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| pin_in | input | 32 | Pad input levels, asynchronous |
| pin_out | output | 32 | Output latch driving the pads |
| pin_oe | output | 32 | Drive enables, 1 = pin is an output |

## Verification
The assertions take for granted that the strobes and `bus_addr` are free of unknowns at every rising edge, and that each strobe describes a single access per cycle. `pin_in` is treated as fully asynchronous, and no property depends on its timing. The stimulus changes all inputs only on falling edges. It applies at most one write and one read per cycle, and it changes `pin_in` while reads are in flight, so that the two-edge lag can be observed.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
  // Byte offsets within the port window.
  localparam int unsigned OFF_DRV_CLR = 32'h100; // rd: drive enables, wr: clear
  localparam int unsigned OFF_DRV_SET = 32'h104; // wr: set drive enables
  localparam int unsigned OFF_LVL_SET = 32'h108; // rd: output latch, wr: set
  localparam int unsigned OFF_LVL_CLR = 32'h10C; // wr: clear output bits
  localparam int unsigned OFF_PIN_ST  = 32'h110; // rd: sampled pins, wr: arm sampling

  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_DRV,
    RSEL_LVL,
    RSEL_PIN
  } rsel_e;
endpackage

// File: rtl/gpio_sc_latch.sv
// Bit-wise set/clear latch: each bit changes only where its mask bit is 1.
module gpio_sc_latch #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] mask,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[i] <= 1'b0;
      end else if (mask[i]) begin
        if (set_stb)      q[i] <= 1'b1;
        else if (clr_stb) q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/gpio_sc_sampler.sv
// Pin sampler: the flops stay cleared until armed, then run two stages.
module gpio_sc_sampler #(
  parameter int W = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] level
);
  logic         armed;
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else if (arm) armed <= 1'b1;
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage[s] <= '0;
      end else if (armed) begin
        if (s == 0) stage[s] <= pin_in;
        else        stage[s] <= stage[s-1];
      end
    end
  end

  assign level = stage[STAGES-1];
endmodule

// File: rtl/gpio_sc_rdmux.sv
// Read path: offset decode and the registered read-data port.
module gpio_sc_rdmux
  import gpio_sc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      drv,
  input  logic [W-1:0]      lvl,
  input  logic [W-1:0]      pins,
  output logic [DATA_W-1:0] rdata
);
  rsel_e             sel;
  logic [W-1:0]      pick;
  logic [DATA_W-1:0] ext;

  always_comb begin
    if (addr == ADDR_W'(OFF_DRV_CLR))     sel = RSEL_DRV;
    else if (addr == ADDR_W'(OFF_LVL_SET)) sel = RSEL_LVL;
    else if (addr == ADDR_W'(OFF_PIN_ST))  sel = RSEL_PIN;
    else                                   sel = RSEL_NONE;
  end

  always_comb begin
    unique case (sel)
      RSEL_DRV: pick = drv;
      RSEL_LVL: pick = lvl;
      RSEL_PIN: pick = pins;
      default:  pick = '0;
    endcase
    ext = '0;
    ext[W-1:0] = pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= ext;
  end
endmodule

// File: rtl/gpio_sc_port.sv
// Set/clear register GPIO port, top level.
module gpio_sc_port
  import gpio_sc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_rd,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);
  localparam int W = NUM_PINS;

  logic         wr_drv_clr, wr_drv_set, wr_lvl_set, wr_lvl_clr, wr_arm;
  logic [W-1:0] mask;
  logic [W-1:0] pin_level;

  assign mask       = bus_wdata[W-1:0];
  assign wr_drv_clr = bus_wr && (bus_addr == ADDR_W'(OFF_DRV_CLR));
  assign wr_drv_set = bus_wr && (bus_addr == ADDR_W'(OFF_DRV_SET));
  assign wr_lvl_set = bus_wr && (bus_addr == ADDR_W'(OFF_LVL_SET));
  assign wr_lvl_clr = bus_wr && (bus_addr == ADDR_W'(OFF_LVL_CLR));
  assign wr_arm     = bus_wr && (bus_addr == ADDR_W'(OFF_PIN_ST));

  gpio_sc_latch #(.W(W)) u_drv (
    .clk(clk), .rst_n(rst_n),
    .set_stb(wr_drv_set), .clr_stb(wr_drv_clr),
    .mask(mask), .q(pin_oe)
  );

  gpio_sc_latch #(.W(W)) u_lvl (
    .clk(clk), .rst_n(rst_n),
    .set_stb(wr_lvl_set), .clr_stb(wr_lvl_clr),
    .mask(mask), .q(pin_out)
  );

  gpio_sc_sampler #(.W(W), .STAGES(2)) u_smp (
    .clk(clk), .rst_n(rst_n),
    .arm(wr_arm), .pin_in(pin_in), .level(pin_level)
  );

  gpio_sc_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .W(W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .rd(bus_rd), .addr(bus_addr),
    .drv(pin_oe), .lvl(pin_out), .pins(pin_level),
    .rdata(bus_rdata)
  );
endmodule

// File: rtl/gpio_sc_port_chk.sv
// Protocol checker for gpio_sc_port, attached via bind below.
module gpio_sc_port_chk
  import gpio_sc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic                bus_rd,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe
);
  logic [NUM_PINS-1:0] wm;
  logic                seen_arm;
  logic                hit_dc, hit_ds, hit_ls, hit_lc, hit_ps, rd_unmapped;

  assign wm     = bus_wdata[NUM_PINS-1:0];
  assign hit_dc = bus_addr == ADDR_W'(OFF_DRV_CLR);
  assign hit_ds = bus_addr == ADDR_W'(OFF_DRV_SET);
  assign hit_ls = bus_addr == ADDR_W'(OFF_LVL_SET);
  assign hit_lc = bus_addr == ADDR_W'(OFF_LVL_CLR);
  assign hit_ps = bus_addr == ADDR_W'(OFF_PIN_ST);
  assign rd_unmapped = !(hit_dc || hit_ls || hit_ps);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_arm <= 1'b0;
    else if (bus_wr && hit_ps) seen_arm <= 1'b1;
  end

  AST_DRV_SET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && hit_ds |=> (pin_oe & $past(wm)) == $past(wm)); // R2
  AST_DRV_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && hit_dc |=> (pin_oe & $past(wm)) == '0); // R3
  AST_LVL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && hit_ls |=> (pin_out & $past(wm)) == $past(wm)); // R4
  AST_LVL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && hit_lc |=> (pin_out & $past(wm)) == '0); // R5
  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && hit_ps && !seen_arm |=> bus_rdata == '0); // R6
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R9
  AST_UNMAPPED_RD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && rd_unmapped |=> bus_rdata == '0); // R10
  AST_DRV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (hit_ds || hit_dc)) |=> $stable(pin_oe)); // R10
  AST_LVL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (hit_ls || hit_lc)) |=> $stable(pin_out)); // R10
endmodule

bind gpio_sc_port gpio_sc_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PINS(NUM_PINS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpio_sc_port_bench.sv
module gpio_sc_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_rdata;
  logic [31:0]   pin_in = '0;
  logic [31:0]   pin_out;
  logic [31:0]   pin_oe;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_sc_port u_gpio_sc_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // Behavioural reference model, updated at every rising edge.
  logic [31:0] m_oe = '0, m_out = '0, m_rdata = '0;
  bit          m_on = 1'b0;
  logic [31:0] m_hist[$];

  function automatic logic [31:0] m_read(input logic [AW-1:0] a);
    case (a)
      12'h100: return m_oe;
      12'h108: return m_out;
      12'h110: return (m_hist.size() >= 2) ? m_hist[m_hist.size()-2] : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_oe = '0; m_out = '0; m_rdata = '0; m_on = 1'b0; m_hist.delete();
    end else begin
      if (bus_rd) m_rdata = m_read(bus_addr);
      if (m_on) begin
        m_hist.push_back(pin_in);
        if (m_hist.size() > 2) void'(m_hist.pop_front());
      end
      if (bus_wr) begin
        case (bus_addr)
          12'h100: m_oe  = m_oe & ~bus_wdata;
          12'h104: m_oe  = m_oe | bus_wdata;
          12'h108: m_out = m_out | bus_wdata;
          12'h10C: m_out = m_out & ~bus_wdata;
          12'h110: m_on  = 1'b1;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every falling edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R2 R3 pin_oe", pin_oe, m_oe);
      check("R4 R5 pin_out", pin_out, m_out);
      check("R9 bus_rdata", bus_rdata, m_rdata);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag, input logic [31:0] exp);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check(tag, bus_rdata, exp);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 bus_rdata", bus_rdata, 32'h0);
    rd(12'h100, "R1 drive read", 32'h0);

    // Drive-enable latch.
    wr(12'h104, 32'h0000_00F5);
    check("R2 set", pin_oe, 32'h0000_00F5);
    wr(12'h104, 32'h0000_0100);
    check("R2 zeros keep", pin_oe, 32'h0000_01F5);
    rd(12'h104, "R2 read zero", 32'h0);
    wr(12'h100, 32'h0000_0011);
    check("R3 clear", pin_oe, 32'h0000_01E4);
    rd(12'h100, "R3 read", 32'h0000_01E4);

    // Output latch.
    wr(12'h108, 32'hA5A5_0003);
    rd(12'h108, "R4 read", 32'hA5A5_0003);
    check("R4 set", pin_out, 32'hA5A5_0003);
    wr(12'h10C, 32'h8000_0001);
    check("R5 clear", pin_out, 32'h25A5_0002);
    rd(12'h10C, "R5 read zero", 32'h0);

    // Sampling off.
    pin_in = 32'hDEAD_BEEF;
    idle(3);
    rd(12'h110, "R6 quiet", 32'h0);

    // Arm with zero data.
    wr(12'h110, 32'h0);
    idle(3);
    rd(12'h110, "R7 armed", 32'hDEAD_BEEF);

    // Two-edge lag: continuous reads after a pin change.
    pin_in = 32'h1234_5678;
    bus_addr = 12'h110; bus_rd = 1'b1;
    @(negedge clk); check("R8 lag edge1", bus_rdata, 32'hDEAD_BEEF);
    @(negedge clk); check("R8 lag edge2", bus_rdata, 32'hDEAD_BEEF);
    @(negedge clk); check("R8 lag edge3", bus_rdata, 32'h1234_5678);
    bus_rd = 1'b0;
    wr(12'h110, 32'hFFFF_FFFF);
    idle(2);
    rd(12'h110, "R7 stays on", 32'h1234_5678);

    // Read and write in the same cycle; rdata then holds.
    bus_addr = 12'h108; bus_rd = 1'b1; bus_wr = 1'b1; bus_wdata = 32'h0000_0100;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    check("R9 pre-write", bus_rdata, 32'h25A5_0002);
    idle(3);
    check("R9 hold", bus_rdata, 32'h25A5_0002);
    check("R4 after", pin_out, 32'h25A5_0102);

    // Unmapped offsets.
    wr(12'h1F0, 32'hFFFF_FFFF);
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h114, 32'hFFFF_FFFF);
    check("R10 oe unchanged", pin_oe, 32'h0000_01E4);
    check("R10 out unchanged", pin_out, 32'h25A5_0102);
    rd(12'h1F0, "R10 read zero", 32'h0);
    rd(12'h10C, "R10 read 10C", 32'h0);
    rd(12'h100, "R10 drive intact", 32'h0000_01E4);

    // Changing pins with mixed traffic, checked by the model.
    for (int k = 0; k < 40; k++) begin
      pin_in = pin_in * 32'd1103515245 + 32'd12345;
      bus_addr = (k % 3 == 0) ? 12'h110 : ((k % 3 == 1) ? 12'h100 : 12'h108);
      bus_rd = 1'b1;
      bus_wr = (k % 4 == 0);
      bus_wdata = pin_in ^ 32'h5A5A_5A5A;
      @(negedge clk);
    end
    bus_rd = 1'b0; bus_wr = 1'b0;
    idle(2);

    // Reset returns everything to zero.
    rst_n = 1'b0;
    idle(2);
    check("R1 reset oe", pin_oe, 32'h0);
    check("R1 reset out", pin_out, 32'h0);
    rst_n = 1'b1;
    idle(1);
    rd(12'h110, "R6 off after reset", 32'h0);
    idle(2);
    summary();
  end
endmodule